// File: doc/BRIEF.md
# Display Timing Generator with Skew

The block generates horizontal sync, vertical sync and data-enable for an external display link. It runs on the pixel clock. As it moves through each frame, it pulls pixels from an upstream valid/ready stream and drives colour onto its outputs. Horizontal timing is counted in pixels within a line. All vertical timing is counted differently: it uses absolute pixel-clock offsets from the first clock of the frame. This means the frame length, the vsync pulse, the vertical display window and a vsync skew are all numbers of pixel clocks, not numbers of lines.

Inside the display window, an optional sub-window picks which pixels are taken from the stream. The rest of the window is filled with a border colour. If the stream has no pixel when one is needed, the block substitutes an underflow colour. It then stops pulling, either for the rest of the frame or, when recovery is enabled, until the next line begins.

Every configuration input is captured into shadow registers in two situations: while the generator is idle, and on the clock where the frame counter wraps. A change made mid-frame therefore never tears the picture. The block also gives a one-clock frame-start pulse for interrupt logic.

Top module: `disp_tgen`

## Requirements
- R1: While `rst` is high, `hsync`, `vsync`, `de`, `rgb` and `frame_start` are all 0, and `pix_ready` is 0.
- R2: While running, the line period is `hctl[31:16]` pixels, and `hsync` is active for the first `hctl[15:0]` pixels of each line (horizontal position h < `hctl[15:0]`).
- R3: The frame position p counts pixel clocks from 0 to `vperiod`−1 and then wraps to 0; the horizontal position also returns to 0 at that wrap. `vsync` is active when `vsync_skew` ≤ p < `vsync_skew` + `vpulse`. `frame_start` is 1 for exactly the output clock of p = 0.
- R4: `de` is active when `hwindow[15:0]` ≤ h ≤ `hwindow[31:16]` and `vstart` ≤ p ≤ `vend`. Outside this window `rgb` is 0.
- R5: In `pol_ctl`, bit 0 inverts `hsync`, bit 1 inverts `vsync` and bit 2 inverts `de`. A set bit makes that output active-low, and its idle level is 1.
- R6: `pix_ready` is high, in the clock where the counters hold a position, exactly when that position is inside both the window and the sub-window and no underflow is being held. A pixel accepted there appears on `rgb` in the next clock, together with the sync and enable levels for that position. All outputs lag the counters by one register stage.
- R7: `sub_hen` limits the sub-window to `sub_hwindow[15:0]` ≤ h ≤ `sub_hwindow[31:16]`, and `sub_ven` limits it to `sub_vstart` ≤ p ≤ `sub_vend`. Window pixels outside the sub-window show `border_color` and are not pulled.
- R8: When `pix_ready` is high and `pix_valid` is low, that position shows `uflow_color`. With `uflow_recover` low, every later sub-window position of the frame also shows `uflow_color` and `pix_ready` stays low until the frame wraps.
- R9: With `uflow_recover` high, the underflow hold ends at the end of the line, and pulling resumes at h = 0 of the next line.
- R10: Raising `tg_enable` starts the generator. The counters hold position 0 one clock later, and the outputs for position 0 appear one clock after that. Lowering `tg_enable` drops `pix_ready` at once. From the next clock, outputs sit at their inactive levels with `rgb` = 0 and no `frame_start`, and a restart begins again at position 0.
- R11: All configuration inputs are captured while idle and on the frame-wrap clock only. A change made mid-frame takes effect from p = 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| tg_enable | input | 1 | Run the generator |
| hctl | input | 32 | Line period [31:16], hsync width [15:0] |
| vperiod | input | VW | Frame length in pixel clocks |
| vpulse | input | VW | Vsync width in pixel clocks |
| vsync_skew | input | VW | Vsync start offset in pixel clocks |
| hwindow | input | 32 | Last active pixel [31:16], first [15:0] |
| vstart | input | VW | First active pixel-clock offset of the frame |
| vend | input | VW | Last active pixel-clock offset of the frame |
| pol_ctl | input | 3 | Active-low select: hsync, vsync, de |
| border_color | input | CW | Colour outside the sub-window |
| uflow_color | input | CW | Colour substituted on underflow |
| uflow_recover | input | 1 | Resume pulling at the next line |
| sub_hen | input | 1 | Enable horizontal sub-window limit |
| sub_ven | input | 1 | Enable vertical sub-window limit |
| sub_hwindow | input | 32 | Sub-window last [31:16], first [15:0] pixel |
| sub_vstart | input | VW | Sub-window first pixel-clock offset |
| sub_vend | input | VW | Sub-window last pixel-clock offset |
| pix_valid | input | 1 | Upstream pixel available |
| pix_data | input | CW | Upstream pixel colour |
| pix_ready | output | 1 | Pixel taken this clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | CW | Output colour |
| frame_start | output | 1 | One-clock pulse at frame position 0 |

## Verification
The bench walks every pixel-clock position of several small frames and compares each output against arithmetic on the position. The cases it targets each expose a specific bug:
- An off-by-one in a window comparison moves `de` or the pull by one pixel at the window edges.
- A vsync comparison that ignores the skew asserts too early.
- A design that rejects a missing pixel without latching the underflow pulls stale data on the next cycle.
- Getting recovery wrong shows up either as a line that never resumes or as one that resumes too soon.
- Reloading configuration mid-frame changes the sync width before the frame has wrapped.
- A design that is slow to disable keeps pulling, or emits one more frame-start pulse, after the enable falls.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;

  // Register word carrying two 16-bit pixel indices
  typedef struct packed {
    logic [15:0] hi;
    logic [15:0] lo;
  } idx_pair_t;

  function automatic logic span16(input logic [15:0] v, input idx_pair_t s);
    return (v >= s.lo) && (v <= s.hi);
  endfunction

endpackage

// File: rtl/tgen_timebase.sv
module tgen_timebase #(
  parameter int HW = 16,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] frame_len,
  output logic          act,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] fcnt,
  output logic          line_end,
  output logic          frame_end,
  output logic          reload
);

  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic run;

  assign act       = run & enable;
  assign line_end  = act && (hcnt == line_len - H_ONE);
  assign frame_end = act && (fcnt == frame_len - V_ONE);
  assign reload    = !run || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      hcnt <= '0;
      fcnt <= '0;
    end else if (!enable) begin
      run  <= 1'b0;
      hcnt <= '0;
      fcnt <= '0;
    end else if (!run) begin
      run  <= 1'b1;
      hcnt <= '0;
      fcnt <= '0;
    end else if (frame_end) begin
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + V_ONE;
      hcnt <= line_end ? '0 : hcnt + H_ONE;
    end
  end

  // R3: a frame wrap returns both counters to the origin
  a_r3_wrap_to_origin: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (fcnt == '0 && hcnt == '0));

  // R2: the horizontal count never reaches the line period
  a_r2_hcnt_in_line: assert property (@(posedge clk) disable iff (rst)
    (act && line_len != '0) |-> (hcnt < line_len));

  // R10: a cleared enable parks the counters at zero
  a_r10_idle_parks: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (hcnt == '0 && fcnt == '0));

endmodule

// File: rtl/tgen_window.sv
module tgen_window
  import disp_tgen_pkg::*;
#(
  parameter int HW = 16,
  parameter int VW = 32
) (
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] fcnt,
  input  logic [HW-1:0] hs_width,
  input  idx_pair_t     hwin,
  input  logic [VW-1:0] vs_skew,
  input  logic [VW-1:0] vs_width,
  input  logic [VW-1:0] v_first,
  input  logic [VW-1:0] v_last,
  input  logic          sub_hen,
  input  logic          sub_ven,
  input  idx_pair_t     sub_hwin,
  input  logic [VW-1:0] sub_vfirst,
  input  logic [VW-1:0] sub_vlast,
  output logic          hs_on,
  output logic          vs_on,
  output logic          win,
  output logic          sub
);

  logic [VW-1:0] vs_rel;
  logic          in_v, sub_h_ok, sub_v_ok;

  assign vs_rel = fcnt - vs_skew;

  always_comb begin
    hs_on    = hcnt < hs_width;
    vs_on    = (fcnt >= vs_skew) && (vs_rel < vs_width);
    in_v     = (fcnt >= v_first) && (fcnt <= v_last);
    win      = span16(hcnt, hwin) && in_v;
    sub_h_ok = !sub_hen || span16(hcnt, sub_hwin);
    sub_v_ok = !sub_ven || ((fcnt >= sub_vfirst) && (fcnt <= sub_vlast));
    sub      = sub_h_ok && sub_v_ok;
  end

endmodule

// File: rtl/tgen_pixel.sv
module tgen_pixel #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic          line_end,
  input  logic          frame_end,
  input  logic          at_origin,
  input  logic          hs_on,
  input  logic          vs_on,
  input  logic          win,
  input  logic          sub,
  input  logic [2:0]    pol,
  input  logic [CW-1:0] border,
  input  logic [CW-1:0] uf_color,
  input  logic          recover,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_data,
  output logic          pix_ready,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] rgb_o,
  output logic          frame_start_o
);

  logic hold, take, starve, hold_clr;

  assign pix_ready = act && win && sub && !hold;
  assign take      = pix_ready && pix_valid;
  assign starve    = pix_ready && !pix_valid;
  assign hold_clr  = !act || frame_end || (recover && line_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= 1'b0;
    end else if (hold_clr) begin
      hold <= 1'b0;
    end else if (starve) begin
      hold <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      de_o          <= 1'b0;
      rgb_o         <= '0;
      frame_start_o <= 1'b0;
    end else if (!act) begin
      hsync_o       <= pol[0];
      vsync_o       <= pol[1];
      de_o          <= pol[2];
      rgb_o         <= '0;
      frame_start_o <= 1'b0;
    end else begin
      hsync_o       <= hs_on ^ pol[0];
      vsync_o       <= vs_on ^ pol[1];
      de_o          <= win ^ pol[2];
      frame_start_o <= at_origin;
      if (take)
        rgb_o <= pix_data;
      else if (win && sub)
        rgb_o <= uf_color;
      else if (win)
        rgb_o <= border;
      else
        rgb_o <= '0;
    end
  end

  // R8: a starved pull without a clearing boundary blocks the next pull
  a_r8_starve_blocks: assert property (@(posedge clk) disable iff (rst)
    (starve && !hold_clr) |=> !pix_ready);

  // R10: when idle, no colour and no frame pulse leave the block
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !act |=> (rgb_o == '0 && !frame_start_o));

  // R5: idle levels follow the polarity selection
  a_r5_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !act |=> (de_o == $past(pol[2]) && hsync_o == $past(pol[0]) && vsync_o == $past(pol[1])));

  // R6: an accepted pixel reaches the colour output
  a_r6_take_shows: assert property (@(posedge clk) disable iff (rst)
    take |=> (rgb_o == $past(pix_data)));

endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import disp_tgen_pkg::*;
#(
  parameter int CW = 24,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tg_enable,
  input  logic [31:0]   hctl,
  input  logic [VW-1:0] vperiod,
  input  logic [VW-1:0] vpulse,
  input  logic [VW-1:0] vsync_skew,
  input  logic [31:0]   hwindow,
  input  logic [VW-1:0] vstart,
  input  logic [VW-1:0] vend,
  input  logic [2:0]    pol_ctl,
  input  logic [CW-1:0] border_color,
  input  logic [CW-1:0] uflow_color,
  input  logic          uflow_recover,
  input  logic          sub_hen,
  input  logic          sub_ven,
  input  logic [31:0]   sub_hwindow,
  input  logic [VW-1:0] sub_vstart,
  input  logic [VW-1:0] sub_vend,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_data,
  output logic          pix_ready,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] rgb,
  output logic          frame_start
);

  localparam int HW = 16;

  // Shadowed configuration
  idx_pair_t     sh_hctl, sh_hwin, sh_sub_hwin;
  logic [VW-1:0] sh_vperiod, sh_vpulse, sh_skew, sh_vstart, sh_vend;
  logic [VW-1:0] sh_sub_vstart, sh_sub_vend;
  logic [2:0]    sh_pol;
  logic [CW-1:0] sh_border, sh_uf;
  logic          sh_recover, sh_sub_hen, sh_sub_ven;

  logic          act, line_end, frame_end, reload, at_origin;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] fcnt;
  logic          hs_on, vs_on, win, sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_hctl       <= '0;
      sh_hwin       <= '0;
      sh_sub_hwin   <= '0;
      sh_vperiod    <= '0;
      sh_vpulse     <= '0;
      sh_skew       <= '0;
      sh_vstart     <= '0;
      sh_vend       <= '0;
      sh_sub_vstart <= '0;
      sh_sub_vend   <= '0;
      sh_pol        <= '0;
      sh_border     <= '0;
      sh_uf         <= '0;
      sh_recover    <= 1'b0;
      sh_sub_hen    <= 1'b0;
      sh_sub_ven    <= 1'b0;
    end else if (reload) begin
      sh_hctl       <= hctl;
      sh_hwin       <= hwindow;
      sh_sub_hwin   <= sub_hwindow;
      sh_vperiod    <= vperiod;
      sh_vpulse     <= vpulse;
      sh_skew       <= vsync_skew;
      sh_vstart     <= vstart;
      sh_vend       <= vend;
      sh_sub_vstart <= sub_vstart;
      sh_sub_vend   <= sub_vend;
      sh_pol        <= pol_ctl;
      sh_border     <= border_color;
      sh_uf         <= uflow_color;
      sh_recover    <= uflow_recover;
      sh_sub_hen    <= sub_hen;
      sh_sub_ven    <= sub_ven;
    end
  end

  tgen_timebase #(.HW(HW), .VW(VW)) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .enable    (tg_enable),
    .line_len  (sh_hctl.hi),
    .frame_len (sh_vperiod),
    .act       (act),
    .hcnt      (hcnt),
    .fcnt      (fcnt),
    .line_end  (line_end),
    .frame_end (frame_end),
    .reload    (reload)
  );

  assign at_origin = act && (fcnt == '0) && (hcnt == '0);

  tgen_window #(.HW(HW), .VW(VW)) u_window (
    .hcnt       (hcnt),
    .fcnt       (fcnt),
    .hs_width   (sh_hctl.lo),
    .hwin       (sh_hwin),
    .vs_skew    (sh_skew),
    .vs_width   (sh_vpulse),
    .v_first    (sh_vstart),
    .v_last     (sh_vend),
    .sub_hen    (sh_sub_hen),
    .sub_ven    (sh_sub_ven),
    .sub_hwin   (sh_sub_hwin),
    .sub_vfirst (sh_sub_vstart),
    .sub_vlast  (sh_sub_vend),
    .hs_on      (hs_on),
    .vs_on      (vs_on),
    .win        (win),
    .sub        (sub)
  );

  tgen_pixel #(.CW(CW)) u_pixel (
    .clk           (clk),
    .rst           (rst),
    .act           (act),
    .line_end      (line_end),
    .frame_end     (frame_end),
    .at_origin     (at_origin),
    .hs_on         (hs_on),
    .vs_on         (vs_on),
    .win           (win),
    .sub           (sub),
    .pol           (sh_pol),
    .border        (sh_border),
    .uf_color      (sh_uf),
    .recover       (sh_recover),
    .pix_valid     (pix_valid),
    .pix_data      (pix_data),
    .pix_ready     (pix_ready),
    .hsync_o       (hsync),
    .vsync_o       (vsync),
    .de_o          (de),
    .rgb_o         (rgb),
    .frame_start_o (frame_start)
  );

  // R11: shadow values hold steady between frame boundaries while running
  a_r11_shadow_steady: assert property (@(posedge clk) disable iff (rst)
    (act && !frame_end) |=> ($stable(sh_hctl) && $stable(sh_pol) && $stable(sh_vperiod)));

endmodule

// File: tb/disp_tgen_tb.sv
`timescale 1ns/1ps
module disp_tgen_tb;
  localparam int CW = 24;
  localparam int VW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          tg_enable = 0;
  logic [31:0]   hctl, hwindow, sub_hwindow;
  logic [VW-1:0] vperiod, vpulse, vsync_skew, vstart, vend, sub_vstart, sub_vend;
  logic [2:0]    pol_ctl;
  logic [CW-1:0] border_color, uflow_color, pix_data;
  logic          uflow_recover, sub_hen, sub_ven, pix_valid;
  logic          pix_ready, hsync, vsync, de, frame_start;
  logic [CW-1:0] rgb;

  disp_tgen #(.CW(CW), .VW(VW)) u_dut (
    .clk(clk), .rst(rst), .tg_enable(tg_enable), .hctl(hctl), .vperiod(vperiod),
    .vpulse(vpulse), .vsync_skew(vsync_skew), .hwindow(hwindow), .vstart(vstart),
    .vend(vend), .pol_ctl(pol_ctl), .border_color(border_color),
    .uflow_color(uflow_color), .uflow_recover(uflow_recover), .sub_hen(sub_hen),
    .sub_ven(sub_ven), .sub_hwindow(sub_hwindow), .sub_vstart(sub_vstart),
    .sub_vend(sub_vend), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb),
    .frame_start(frame_start)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model copies of the active configuration
  int m_per, m_hpw, m_hf, m_hl, m_vp, m_vpw, m_sk, m_vs, m_ve;
  int m_shf, m_shl, m_svs, m_sve;
  bit m_shen, m_sven, m_rec;
  logic [2:0]    m_pol;
  logic [CW-1:0] m_bord, m_uf;

  int drop_lo = -1, drop_hi = -1, chg_at = -1;
  logic [CW-1:0] dval = 24'h000100;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic base_cfg();
    hctl = {16'd10, 16'd2}; hwindow = {16'd8, 16'd3};
    vperiod = 60; vpulse = 10; vsync_skew = 0; vstart = 20; vend = 49;
    pol_ctl = 3'b000; border_color = 24'hABCDEF; uflow_color = 24'h123456;
    uflow_recover = 0; sub_hen = 0; sub_ven = 0;
    sub_hwindow = {16'd6, 16'd4}; sub_vstart = 30; sub_vend = 39;
    pix_valid = 1; pix_data = dval;
  endtask

  task automatic latch_model();
    m_per = int'(hctl[31:16]); m_hpw = int'(hctl[15:0]);
    m_hl = int'(hwindow[31:16]); m_hf = int'(hwindow[15:0]);
    m_vp = int'(vperiod); m_vpw = int'(vpulse); m_sk = int'(vsync_skew);
    m_vs = int'(vstart); m_ve = int'(vend);
    m_shl = int'(sub_hwindow[31:16]); m_shf = int'(sub_hwindow[15:0]);
    m_svs = int'(sub_vstart); m_sve = int'(sub_vend);
    m_shen = sub_hen; m_sven = sub_ven; m_rec = uflow_recover;
    m_pol = pol_ctl; m_bord = border_color; m_uf = uflow_color;
  endtask

  task automatic apply_change();
    hctl = {16'd10, 16'd4}; hwindow = {16'd7, 16'd2}; pol_ctl = 3'b010;
  endtask

  // R10 start: enable, then walk n positions from the origin
  task automatic run(input int n);
    int p = 0, h = 0;
    bit hold = 0;
    tg_enable = 1;
    @(negedge clk);
    latch_model();
    for (int k = 0; k < n; k++) begin
      bit w, s, r;
      logic [CW-1:0] exp_rgb;
      string ctag;
      if (p == 0 && k != 0) latch_model();
      if (k == chg_at) apply_change();
      pix_valid = !(k >= drop_lo && k < drop_hi);
      pix_data = dval;
      w = (h >= m_hf) && (h <= m_hl) && (p >= m_vs) && (p <= m_ve);
      s = (!m_shen || (h >= m_shf && h <= m_shl)) && (!m_sven || (p >= m_svs && p <= m_sve));
      r = w && s && !hold;
      chk("R6 ready", pix_ready, r);
      @(negedge clk);
      if (r && pix_valid) begin exp_rgb = dval; dval++; ctag = "R6 pixel"; end
      else if (r) begin exp_rgb = m_uf; hold = 1; ctag = "R8 starve"; end
      else if (w && s) begin exp_rgb = m_uf; ctag = "R8/R9 hold"; end
      else if (w) begin exp_rgb = m_bord; ctag = "R7 border"; end
      else begin exp_rgb = '0; ctag = "R4 blank"; end
      chk(ctag, rgb, exp_rgb);
      chk("R2/R5 hsync", hsync, (h < m_hpw) ^ m_pol[0]);
      chk("R3/R5 vsync", vsync, ((p >= m_sk) && (p - m_sk < m_vpw)) ^ m_pol[1]);
      chk("R4/R5 de", de, w ^ m_pol[2]);
      chk("R3 frame_start", frame_start, p == 0);
      if (p == m_vp - 1 || (m_rec && h == m_per - 1)) hold = 0;
      if (p == m_vp - 1) begin p = 0; h = 0; end
      else begin p++; h = (h == m_per - 1) ? 0 : h + 1; end
    end
  endtask

  // R10 stop: idle levels from the next clock
  task automatic stop();
    tg_enable = 0;
    #0.1;
    chk("R10 ready drop", pix_ready, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 idle de", de, pol_ctl[2]);
      chk("R10 idle hsync", hsync, pol_ctl[0]);
      chk("R10 idle rgb", rgb, 0);
      chk("R10 no frame_start", frame_start, 0);
      chk("R10 no pull", pix_ready, 0);
    end
  endtask

  initial begin
    base_cfg();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hsync", hsync, 0); chk("R1 vsync", vsync, 0); chk("R1 de", de, 0);
    chk("R1 rgb", rgb, 0); chk("R1 frame_start", frame_start, 0);
    chk("R1 ready", pix_ready, 0);
    rst = 0;
    // R5 idle polarity levels
    pol_ctl = 3'b111;
    repeat (2) @(negedge clk);
    chk("R5 idle hsync", hsync, 1); chk("R5 idle vsync", vsync, 1);
    chk("R5 idle de", de, 1);
    pol_ctl = 3'b000;
    repeat (2) @(negedge clk);
    // R2 R3 R4 R6 basic frames
    run(130); stop();
    // R5 polarity with R3 skew
    pol_ctl = 3'b111; vsync_skew = 3;
    run(130); stop();
    base_cfg();
    // R7 sub-window both limits, then vertical only
    sub_hen = 1; sub_ven = 1;
    run(70); stop();
    sub_hen = 0;
    run(70); stop();
    base_cfg();
    // R8 underflow held to frame end
    drop_lo = 33; drop_hi = 35;
    run(130); stop();
    // R9 recovery at the next line
    uflow_recover = 1;
    run(130); stop();
    drop_lo = -1; drop_hi = -1;
    base_cfg();
    // R11 mid-frame change waits for the wrap
    chg_at = 25;
    run(130); stop();
    chg_at = -1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule